// File: doc/BRIEF.md
# Switchable-Ratio Polyphase Interpolator

This block raises the sample rate of a stream of 16-bit signed samples by a rational factor L/M. It is built as a polyphase filter and does not build the zero-stuffed stream that a plain upsampler would produce. It keeps only the four most recent real input samples. A phase register picks one of L coefficient sets for each output. The same register decides when the window of four samples must take in the next input. Each output is the weighted sum of the four samples. The four products come from four multipliers and are summed in a registered adder tree.

Two ratios share one datapath. With `ratio_sel` at 0 the factor is 7/2, and with it at 1 the factor is 8/2. The two modes differ only in the coefficient bank and in the wrap limit of the phase register. Input arrives on a valid/ready port and results leave on a valid-only port. The ratio is latched at reset or at a flush, and a flush also empties the history and the pipeline. With a 250 MHz clock and input at 28.57 or 25 MSPS, the block produces about 100 MSPS.

Top module: `ratio_interp`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The coefficients are cubic Lagrange weights in Q14. For phase p of L and taps k=0..3, applied from oldest to newest sample, each weight is trunc(n_k·16384 / (6·L³)), truncated toward zero. The numerators are n0=−p(p−L)(p−2L), n1=3(p+L)(p−L)(p−2L), n2=−3(p+L)p(p−2L) and n3=(p+L)p(p−L).
- R3: Each output is (Σ c_k·s_k + 8192) shifted arithmetically right by 14 bits, then saturated to the range −32768..32767.
- R4: The phase starts at 0 and the first output uses inputs x0..x3. After each output the phase becomes p+2. If that sum is at least L, L is subtracted and the window advances by one input. At phase 0 the output equals the second-oldest sample of the window.
- R5: When the next window needs a sample that has not arrived, no output is produced, the phase holds and `out_data` keeps its last value. For N inputs, the outputs are exactly those of the windows whose newest sample index is below N.
- R6: `ratio_sel` (0 = 7/2, 1 = 8/2) is sampled only in a cycle where reset or `flush` is active. Changing it at any other time has no effect on the outputs.
- R7: A flush clears the phase, the sample history and every result in flight. After a reset or a flush, `out_valid` stays 0 until four new samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Clears state and latches `ratio_sel` |
| ratio_sel | input | 1 | 0 selects 7/2, 1 selects 8/2 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Signed output sample |

## Verification
Random samples with random idle gaps in 7/2 mode test the stalling and the phase-to-window mapping. Continuous random input in 8/2 mode tests the other bank and the full back-to-back rate. A pattern of alternating full-scale values pushes the Lagrange overshoot into the clamp, which separates correct saturation from a wrapped result. In a short ramp, phase-0 outputs must equal an input sample exactly. Toggling the ratio mid-stream without a flush, and supplying only three samples after a flush, show whether the mode latch and the fill guard are respected.

// File: rtl/ratio_interp.sv
module ratio_interp #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int FRAC   = 14,
  parameter int L_A    = 7,
  parameter int L_B    = 8,
  parameter int M_DOWN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ratio_sel,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int TAPS  = 4;
  localparam int L_MAX = (L_A > L_B) ? L_A : L_B;
  localparam int PW    = $clog2(L_MAX + M_DOWN);
  localparam int IW    = $clog2(L_MAX);
  localparam int FW    = $clog2(TAPS + 1);
  localparam int PRODW = DW + CW;
  localparam int ACCW  = PRODW + 2;
  localparam logic [FW-1:0] FULL = FW'(TAPS);
  localparam logic [PW-1:0] LA_W = PW'(L_A);
  localparam logic [PW-1:0] LB_W = PW'(L_B);
  localparam logic [PW-1:0] M_W  = PW'(M_DOWN);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -ACCW'(1 <<< (DW - 1));

  function automatic int lag_coef(input int l, input int p, input int k);
    longint n, lw, pw;
    lw = longint'(l);
    pw = longint'(p);
    case (k)
      0:       n = -pw * (pw - lw) * (pw - 2 * lw);
      1:       n = 3 * (pw + lw) * (pw - lw) * (pw - 2 * lw);
      2:       n = -3 * (pw + lw) * pw * (pw - 2 * lw);
      default: n = (pw + lw) * pw * (pw - lw);
    endcase
    return int'((n * (longint'(1) <<< FRAC)) / (6 * lw * lw * lw));
  endfunction

  logic signed [CW-1:0] bank_a [L_MAX][TAPS];
  logic signed [CW-1:0] bank_b [L_MAX][TAPS];

  for (genvar gp = 0; gp < L_MAX; gp++) begin : g_ph
    for (genvar gk = 0; gk < TAPS; gk++) begin : g_tap
      assign bank_a[gp][gk] = (gp < L_A) ? CW'(lag_coef(L_A, gp, gk)) : '0;
      assign bank_b[gp][gk] = (gp < L_B) ? CW'(lag_coef(L_B, gp, gk)) : '0;
    end
  end

  logic                 mode_q, need;
  logic [PW-1:0]        ph;
  logic [FW-1:0]        fill;
  logic signed [DW-1:0] hist [TAPS];

  logic [PW-1:0] l_act, ph_sum, ph_nxt;
  logic          issue, accept, wrap;

  assign l_act    = mode_q ? LB_W : LA_W;
  assign issue    = (fill == FULL) && !need;
  assign in_ready = !issue;
  assign accept   = in_valid && in_ready;
  assign ph_sum   = ph + M_W;
  assign wrap     = ph_sum >= l_act;
  assign ph_nxt   = wrap ? ph_sum - l_act : ph_sum;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      mode_q <= ratio_sel;
      ph     <= '0;
      fill   <= '0;
      need   <= 1'b0;
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else begin
      if (accept) begin
        for (int i = 0; i < TAPS - 1; i++) hist[i] <= hist[i+1];
        hist[TAPS-1] <= in_data;
        if (fill != FULL) fill <= fill + 1'b1;
        need <= 1'b0;
      end
      if (issue) begin
        ph   <= ph_nxt;
        need <= wrap;
      end
    end
  end

  logic signed [PRODW-1:0] prod [TAPS];
  logic signed [ACCW-1:0]  pair0, pair1, tot, shr;
  logic                    v1, v2;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= issue;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) prod[i] <= '0;
      pair0    <= '0;
      pair1    <= '0;
      out_data <= '0;
    end else begin
      if (issue)
        for (int i = 0; i < TAPS; i++)
          prod[i] <= (mode_q ? bank_b[ph[IW-1:0]][i] : bank_a[ph[IW-1:0]][i]) * hist[i];
      if (v1) begin
        pair0 <= ACCW'(prod[0]) + ACCW'(prod[1]);
        pair1 <= ACCW'(prod[2]) + ACCW'(prod[3]);
      end
      if (v2)
        out_data <= (shr > MAXV) ? DW'(MAXV) : (shr < MINV) ? DW'(MINV) : shr[DW-1:0];
    end
  end

  assign tot = pair0 + pair1 + HALF;
  assign shr = tot >>> FRAC;

  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph < l_act);
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !flush) |=> $stable(ph));
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable(out_data));
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(mode_q));
  a_r7_flush_kills: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: tb/ratio_interp_tb.sv
module ratio_interp_tb;
  logic clk = 0, rst_n = 0, flush = 0, ratio_sel = 0, in_valid = 0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;
  int errors = 0, checks = 0;
  bit done = 0;
  int got[$];
  int sent[$];

  always #5 clk = ~clk;

  ratio_interp u_dut (.clk(clk), .rst_n(rst_n), .flush(flush), .ratio_sel(ratio_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always @(negedge clk) if (rst_n && out_valid) got.push_back(int'($signed(out_data)));

  function automatic int coef(int l, int p, int k);
    longint n;
    case (k)
      0: n = -longint'(p) * (p - l) * (p - 2 * l);
      1: n = 3 * longint'(p + l) * (p - l) * (p - 2 * l);
      2: n = -3 * longint'(p + l) * p * (p - 2 * l);
      default: n = longint'(p + l) * p * (p - l);
    endcase
    return int'((n * 16384) / (6 * longint'(l) * l * l));
  endfunction

  function automatic int rnd_sat(longint acc);
    longint r = (acc + 8192) >>> 14;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(int l, output int q[$]);
    int n = 0, ph = 0;
    longint acc;
    q = {};
    while (n + 3 < sent.size()) begin
      acc = 0;
      for (int k = 0; k < 4; k++) acc += longint'(coef(l, ph, k)) * sent[n+k];
      q.push_back(rnd_sat(acc));
      ph += 2;
      if (ph >= l) begin ph -= l; n++; end
    end
  endtask

  task automatic send(int v, int gap_pct);
    while ($urandom_range(99) < gap_pct) begin
      @(negedge clk); in_valid = 0;
    end
    @(negedge clk);
    while (!in_ready) begin in_valid = 0; @(negedge clk); end
    in_valid = 1; in_data = 16'(v);
    sent.push_back(v);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic restart(bit by_reset, bit m);
    @(negedge clk);
    ratio_sel = m;
    if (by_reset) rst_n = 0; else flush = 1;
    @(negedge clk);
    rst_n = 1; flush = 0;
    sent = {}; got = {};
  endtask

  task automatic finish_cmp(int l, string tag);
    int exp[$];
    logic [15:0] held;
    repeat (20) @(negedge clk);
    model(l, exp);
    check(got.size() == exp.size(), {tag, " R5 output count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(got[i] == exp[i], {tag, " R2 R3 R4 sample"}, got[i], exp[i]);
    held = out_data;
    repeat (8) @(negedge clk);
    check(!out_valid && out_data == held, {tag, " R5 hold when starved"},
          int'($signed(out_data)), int'($signed(held)));
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    restart(1, 0);
    for (int i = 0; i < 3; i++) send($urandom_range(65535) - 32768, 0);
    repeat (10) @(negedge clk);
    check(got.size() == 0, "R7 no output before four samples", got.size(), 0);
    for (int i = 0; i < 60; i++) begin
      if (i == 30) ratio_sel = 1;
      send($urandom_range(65535) - 32768, 40);
    end
    finish_cmp(7, "R6 7/2 random gaps, mode toggled");
    restart(0, 1);
    for (int i = 0; i < 60; i++) send($urandom_range(65535) - 32768, 0);
    finish_cmp(8, "8/2 continuous");
    restart(0, 0);
    for (int i = 0; i < 40; i++) send((i % 4 == 1 || i % 4 == 2) ? 32767 : -32768, 10);
    finish_cmp(7, "R3 saturation pattern");
    restart(0, 1);
    for (int i = 0; i < 12; i++) send(100 * i - 300, 0);
    check(got.size() > 0 && got[0] == -200, "R4 phase-0 output equals x1",
          got.size() > 0 ? got[0] : 0, -200);
    finish_cmp(8, "8/2 ramp");
    restart(0, 0);
    for (int i = 0; i < 6; i++) send(1000 * i, 0);
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    sent = {}; got = {};
    repeat (10) @(negedge clk);
    check(got.size() == 0, "R7 flush discards in-flight", got.size(), 0);
    for (int i = 0; i < 20; i++) send($urandom_range(2000) - 1000, 20);
    finish_cmp(7, "R7 after flush");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule